// File: doc/BRIEF.md
# Gate Driver Fault and Enable Supervisor

This block decides whether a synchronous-buck gate sequencer may switch, and it guards start-up against a pre-charged output. It takes four comparator flags: supply above the start threshold, supply below the hysteresis threshold, soft-start above its check level, and switch node above its check level. It also takes the level seen on a shared enable line. All five inputs are asynchronous. Each passes through its own synchronizer chain before any decision uses it.

A supply lockout holds the sequencer off until the supply has crossed the start threshold. Once the supply is good, only the lower hysteresis flag can take that permission away again. If the soft-start and switch-node flags are both high while the supply is good, the block latches a fault and requests the low-side switch on, which discharges the output. Only a supply recycle clears that fault. While the supply is locked out or a fault is latched, the block pulls the shared enable line low, and that shuts down the controller that owns the line.

Top module: `drv_fault_supervisor`

## Requirements
- R1: Out of reset, and until the lockout releases, `run_ok` is 0, `force_low_on` is 0, `fault_latched` is 0 and `en_pull_low` is 1.
- R2: The lockout releases when the synchronized start flag is 1 and the synchronized hysteresis flag is 0. After release, only the hysteresis flag set to 1 re-enters lockout. A start flag that falls alone has no effect.
- R3: While the supply is good, soft-start flag 1 together with switch-node flag 1 sets `fault_latched` and `force_low_on` to 1 in the following cycle.
- R4: A latched fault stays set under any flag pattern except lockout entry. Entering lockout clears it.
- R5: `en_pull_low` is 1 while the supply is locked out or a fault is latched.
- R6: `run_ok` is 1 exactly when the supply is good, no fault is latched and the synchronized enable level is 1.
- R7: Every input passes `SYNC_STAGES` (default 2) flops. An input change applied before clock edge N shows on `run_ok` just after edge N+SYNC_STAGES.
- R8: `en_pull_low` follows the lockout/fault condition one cycle late. It releases on the edge after the one where `run_ok` becomes able to rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vin_start_raw | input | 1 | Supply above start threshold (async) |
| vin_hyst_low_raw | input | 1 | Supply below hysteresis threshold (async) |
| ss_high_raw | input | 1 | Soft-start above check level (async) |
| sw_high_raw | input | 1 | Switch node above check level (async) |
| en_line_in | input | 1 | Level observed on the shared enable line (async) |
| run_ok | output | 1 | Gate sequencing permitted |
| force_low_on | output | 1 | Request low-side switch on for discharge |
| fault_latched | output | 1 | Start-up fault latched |
| en_pull_low | output | 1 | Drive the shared enable line low |

## Verification
The bench sweeps all 32 input patterns from each of three starting conditions: locked out, running and faulted. This catches a fault that clears without a recycle, a start flag that falls and wrongly drops the supply, or a release that does not wait for the hysteresis flag to clear. It times the first run permission and the enable release edge by edge. A synchronizer one flop short, or a pull-down that tracks the condition combinationally, therefore shows up as a one-cycle shift. It also applies the fault pattern while still locked out, where a trap that fires without a good supply would latch a fault that should never exist.

// File: rtl/drv_sup_pkg.sv
package drv_sup_pkg;

   localparam int unsigned FLAG_COUNT = 5;

   typedef struct packed {
      logic en_high;
      logic sw_high;
      logic ss_high;
      logic hyst_low;
      logic start_ok;
   } sup_flags_t;

endpackage

// File: rtl/sup_sync_bank.sv
module sup_sync_bank #(
   parameter int unsigned WIDTH  = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   localparam int unsigned LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sup_sync_bank: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("sup_sync_bank: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= '0;
               else        chain_q[s] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= '0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain_q[LAST];

endmodule

// File: rtl/sup_lockout.sv
module sup_lockout (
   input  logic clk,
   input  logic rst_n,
   input  logic start_ok_s,
   input  logic hyst_low_s,
   output logic supply_good
);

   logic locked_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_q <= 1'b1;
      end else if (locked_q) begin
         if (start_ok_s && !hyst_low_s) locked_q <= 1'b0;
      end else if (hyst_low_s) begin
         locked_q <= 1'b1;
      end
   end

   assign supply_good = !locked_q;

endmodule

// File: rtl/sup_startup_trap.sv
module sup_startup_trap (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_good,
   input  logic ss_high_s,
   input  logic sw_high_s,
   output logic trap_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trap_q <= 1'b0;
      end else if (!supply_good) begin
         trap_q <= 1'b0;
      end else if (ss_high_s && sw_high_s) begin
         trap_q <= 1'b1;
      end
   end

endmodule

// File: rtl/drv_fault_supervisor.sv
module drv_fault_supervisor #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vin_start_raw,
   input  logic vin_hyst_low_raw,
   input  logic ss_high_raw,
   input  logic sw_high_raw,
   input  logic en_line_in,
   output logic run_ok,
   output logic force_low_on,
   output logic fault_latched,
   output logic en_pull_low
);
   import drv_sup_pkg::*;

   sup_flags_t raw_flags;
   sup_flags_t sync_flags;
   logic       supply_good;
   logic       trap_q;
   logic       pull_q;

   assign raw_flags.start_ok = vin_start_raw;
   assign raw_flags.hyst_low = vin_hyst_low_raw;
   assign raw_flags.ss_high  = ss_high_raw;
   assign raw_flags.sw_high  = sw_high_raw;
   assign raw_flags.en_high  = en_line_in;

   sup_sync_bank #(
      .WIDTH (FLAG_COUNT),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in(raw_flags),
      .sync_out(sync_flags)
   );

   sup_lockout u_lock (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_ok_s (sync_flags.start_ok),
      .hyst_low_s (sync_flags.hyst_low),
      .supply_good(supply_good)
   );

   sup_startup_trap u_trap (
      .clk        (clk),
      .rst_n      (rst_n),
      .supply_good(supply_good),
      .ss_high_s  (sync_flags.ss_high),
      .sw_high_s  (sync_flags.sw_high),
      .trap_q     (trap_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pull_q <= 1'b1;
      else        pull_q <= !supply_good || trap_q;
   end

   assign run_ok        = supply_good && !trap_q && sync_flags.en_high;
   assign force_low_on  = trap_q;
   assign fault_latched = trap_q;
   assign en_pull_low   = pull_q;

endmodule

// File: rtl/drv_fault_supervisor_chk.sv
module drv_fault_supervisor_chk (
   input logic clk,
   input logic rst_n,
   input logic supply_good,
   input logic start_s,
   input logic hyst_s,
   input logic ss_s,
   input logic sw_s,
   input logic fault_latched,
   input logic en_pull_low,
   input logic run_ok
);

   assert_release_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(supply_good) |-> ($past(start_s) && !$past(hyst_s)));

   assert_drop_on_hyst_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(supply_good) |-> $past(hyst_s));

   assert_trap_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (supply_good && ss_s && sw_s) |=> fault_latched);

   assert_trap_clears_only_recycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault_latched) |-> !$past(supply_good));

   assert_pull_on_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_latched || !supply_good) |=> en_pull_low);

   assert_pull_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (supply_good && !fault_latched) |=> !en_pull_low);

   assert_run_needs_supply_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_ok) |-> !fault_latched);

endmodule

bind drv_fault_supervisor drv_fault_supervisor_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .supply_good  (supply_good),
   .start_s      (sync_flags.start_ok),
   .hyst_s       (sync_flags.hyst_low),
   .ss_s         (sync_flags.ss_high),
   .sw_s         (sync_flags.sw_high),
   .fault_latched(fault_latched),
   .en_pull_low  (en_pull_low),
   .run_ok       (run_ok)
);

// File: tb/drv_fault_supervisor_tb.sv
module drv_fault_supervisor_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_r = 1'b0, hyst_r = 1'b0, ss_r = 1'b0, sw_r = 1'b0, en_r = 1'b0;
   logic run_ok, force_low_on, fault_latched, en_pull_low;
   int   n_checks = 0;
   int   n_fail   = 0;
   bit   done     = 1'b0;

   always #5 clk = ~clk;

   drv_fault_supervisor #(.SYNC_STAGES(2)) u_dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .vin_start_raw   (start_r),
      .vin_hyst_low_raw(hyst_r),
      .ss_high_raw     (ss_r),
      .sw_high_raw     (sw_r),
      .en_line_in      (en_r),
      .run_ok          (run_ok),
      .force_low_on    (force_low_on),
      .fault_latched   (fault_latched),
      .en_pull_low     (en_pull_low)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic edges(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic drive(input logic [4:0] v);
      start_r = v[0]; hyst_r = v[1]; ss_r = v[2]; sw_r = v[3]; en_r = v[4];
   endtask

   task automatic do_reset();
      drive(5'b0);
      rst_n = 1'b0;
      edges(2);
      rst_n = 1'b1;
      edges(1);
   endtask

   // state: 0 locked, 1 running, 2 faulted
   task automatic reach(input int st);
      do_reset();
      if (st >= 1) begin drive(5'b10001); edges(6); end
      if (st == 2) begin drive(5'b11101); edges(6); drive(5'b10001); edges(6); end
   endtask

   initial begin
      logic lk, ft, ex_run;
      do_reset();
      // R1 reset state
      check("R1 run_ok", run_ok, 1'b0);
      check("R1 force_low_on", force_low_on, 1'b0);
      check("R1 fault_latched", fault_latched, 1'b0);
      check("R1 en_pull_low", en_pull_low, 1'b1);

      // R7 / R8 edge timing of first permission
      drive(5'b10001);
      edges(2);
      check("R7 run_ok before sync", run_ok, 1'b0);
      edges(1);
      check("R7 run_ok after sync", run_ok, 1'b1);
      check("R8 pull still held", en_pull_low, 1'b1);
      edges(1);
      check("R8 pull released", en_pull_low, 1'b0);

      // R3 trap while locked out must not fire
      do_reset();
      drive(5'b01100);
      edges(6);
      check("R3 no trap while locked", fault_latched, 1'b0);

      // exhaustive sweep
      for (int st = 0; st < 3; st++) begin
         for (int c = 0; c < 32; c++) begin
            logic [4:0] v;
            v = 5'(c);
            reach(st);
            drive(v);
            edges(6);
            lk = (st == 0);
            ft = (st == 2);
            if (lk) begin
               if (v[0] && !v[1]) lk = 1'b0;
            end else if (v[1]) begin
               lk = 1'b1;
            end
            if (lk) ft = 1'b0;
            else if (v[2] && v[3]) ft = 1'b1;
            ex_run = !lk && !ft && v[4];
            check($sformatf("R2/R6 run_ok st=%0d in=%05b", st, v), run_ok, ex_run);
            check($sformatf("R3/R4 fault st=%0d in=%05b", st, v), fault_latched, ft);
            check($sformatf("R3 force_low st=%0d in=%05b", st, v), force_low_on, ft);
            check($sformatf("R5 pull st=%0d in=%05b", st, v), en_pull_low, lk || ft);
         end
      end

      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule